// File: doc/BRIEF.md
# Look-Ahead XY Route Unit

This unit sits in the input port of a router in a 4x4 wormhole mesh. The mesh routes each packet one hop ahead. Every flit carries a one-hot field that names the output port it must take in the router it has just entered. The current router switches the flit using the value already in that field. This unit works out the value the field must hold for the router after this one, and writes it into the flit.

When a head flit passes through, the unit first finds the coordinates of the neighbouring router. It takes them from this router's own coordinates and the output port named in the incoming field. It then compares the flit's destination with those coordinates. The x difference is corrected first, then the y difference. If both are equal, the packet is delivered locally. The unit writes the result back into the next-port field. Body and tail flits pass through bit for bit. Each flit appears at the output exactly one clock after it is presented.

The flit is 76 bits. The fields, from the least significant bit upwards, are:
- payload: bits 63:0
- tail flag: bit 64
- next-port: bits 69:65
- x destination: bits 72:70
- y destination: bits 75:73

The next-port bits are one-hot:
- bit 0 (field bit 65): north, which is y+1
- bit 1: south, which is y-1
- bit 2: east, which is x+1
- bit 3: west, which is x-1
- bit 4: self, local delivery

Top module: `lar_route_unit`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `outValid` is low, even if `inValid` is high.
- R2: A flit presented with `inValid` high in one cycle appears on `outFlit` with `outValid` high in the next cycle. A cycle with `inValid` low yields `outValid` low in the next cycle.
- R3: A flit that is not a head flit leaves unchanged in all 76 bits, including its next-port field (bits 69:65).
- R4: For a head flit, every bit outside the next-port field (bits 63:0 and 75:70) leaves unchanged.
- R5: The neighbour address is taken from the first set bit of the incoming next-port field, checked in the order north (bit 65, y+1), south (bit 66, y-1), east (bit 67, x+1), west (bit 68, x-1). If none of these bits is set, including the self case, the neighbour address is this router's own address.
- R6: If the destination x (bits 72:70) differs from the neighbour's x, the new field is east (5'b00100) when the destination is greater, and west (5'b01000) otherwise. This holds whatever the y values are.
- R7: If the x values are equal and the destination y (bits 75:73) differs from the neighbour's y, the new field is north (5'b00001) when the destination is greater, and south (5'b00010) otherwise.
- R8: If both coordinates equal the neighbour's, the new field is self (5'b10000).
- R9: A flit is a head flit if it is the first valid flit after reset, or the first valid flit after one whose tail bit (bit 64) is set. A head flit with its tail bit set is a whole packet, and the flit after it is again a head.
- R10: Every head flit leaves with exactly one bit set in its next-port field.
- R11: While `inValid` is low, `outFlit` keeps its last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| myX | input | COORD_W | x coordinate of this router |
| myY | input | COORD_W | y coordinate of this router |
| inValid | input | 1 | A flit is presented on `inFlit` |
| inFlit | input | 76 | Flit leaving the input FIFO |
| outValid | output | 1 | `outFlit` holds a flit |
| outFlit | output | 76 | Flit with its look-ahead field updated |

## Verification
Two functions can fall in the same cycle. The packet-boundary tracker may be closing a packet, because a tail has arrived, in the very cycle a new head must be recognised and rewritten. The bench provokes this with single-flit packets sent back to back with no idle cycle. It uses a full sweep of the 16 destinations, so every flit is both a tail and the head that follows a tail. A scoreboard then requires every one of those flits to come out with its field recomputed, and also requires a packet's body flits to come out untouched.

// File: rtl/lar_pkg.sv
package lar_pkg;
  localparam int FLIT_W  = 76;
  localparam int DATA_W  = 64;
  localparam int TAIL_B  = DATA_W;
  localparam int PORT_W  = 5;
  localparam int PORT_LO = TAIL_B + 1;
  localparam int DEST_W  = 3;
  localparam int XD_LO   = PORT_LO + PORT_W;
  localparam int YD_LO   = XD_LO + DEST_W;

  localparam int P_NORTH = 0;
  localparam int P_SOUTH = 1;
  localparam int P_EAST  = 2;
  localparam int P_WEST  = 3;
  localparam int P_SELF  = 4;

  typedef struct packed {
    logic load;     // capture a flit this cycle
    logic rewrite;  // captured flit is a head: replace its next-port field
  } laStrobe_t;
endpackage

// File: rtl/lar_ctrl.sv
module lar_ctrl
  import lar_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      inValid,
  input  logic      inTail,
  output laStrobe_t strobe,
  output logic      outValid
);
  logic expectHead;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      expectHead <= 1'b1;
      outValid   <= 1'b0;
    end else begin
      outValid <= inValid;
      if (inValid) expectHead <= inTail;
    end
  end

  always_comb begin
    strobe.load    = inValid;
    strobe.rewrite = inValid & expectHead;
  end
endmodule

// File: rtl/lar_dpath.sv
module lar_dpath
  import lar_pkg::*;
#(
  parameter int COORD_W = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [COORD_W-1:0] myX,
  input  logic [COORD_W-1:0] myY,
  input  logic [FLIT_W-1:0]  inFlit,
  input  laStrobe_t          strobe,
  output logic [FLIT_W-1:0]  outFlit
);
  localparam int WIDE_W = ((DEST_W > COORD_W) ? DEST_W : COORD_W) + 1;

  logic [PORT_W-1:0] inPort;
  logic [PORT_W-1:0] newPort;
  logic [WIDE_W-1:0] nextX, nextY, destX, destY;
  logic [FLIT_W-1:0] newFlit;

  assign inPort = inFlit[PORT_LO +: PORT_W];
  assign destX  = WIDE_W'(inFlit[XD_LO +: DEST_W]);
  assign destY  = WIDE_W'(inFlit[YD_LO +: DEST_W]);

  // neighbour address from the port the flit leaves on here
  always_comb begin
    nextX = WIDE_W'(myX);
    nextY = WIDE_W'(myY);
    if (inPort[P_NORTH])     nextY = WIDE_W'(myY) + WIDE_W'(1);
    else if (inPort[P_SOUTH]) nextY = WIDE_W'(myY) - WIDE_W'(1);
    else if (inPort[P_EAST])  nextX = WIDE_W'(myX) + WIDE_W'(1);
    else if (inPort[P_WEST])  nextX = WIDE_W'(myX) - WIDE_W'(1);
  end

  // x first, then y, then local delivery
  always_comb begin
    newPort = '0;
    if (destX > nextX)      newPort[P_EAST]  = 1'b1;
    else if (destX < nextX) newPort[P_WEST]  = 1'b1;
    else if (destY > nextY) newPort[P_NORTH] = 1'b1;
    else if (destY < nextY) newPort[P_SOUTH] = 1'b1;
    else                    newPort[P_SELF]  = 1'b1;
  end

  always_comb begin
    newFlit = inFlit;
    if (strobe.rewrite) newFlit[PORT_LO +: PORT_W] = newPort;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            outFlit <= '0;
    else if (strobe.load) outFlit <= newFlit;
  end
endmodule

// File: rtl/lar_route_unit.sv
module lar_route_unit
  import lar_pkg::*;
#(
  parameter int COORD_W = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [COORD_W-1:0] myX,
  input  logic [COORD_W-1:0] myY,
  input  logic               inValid,
  input  logic [FLIT_W-1:0]  inFlit,
  output logic               outValid,
  output logic [FLIT_W-1:0]  outFlit
);
  laStrobe_t strobe;

  lar_ctrl ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .inTail   (inFlit[TAIL_B]),
    .strobe   (strobe),
    .outValid (outValid)
  );

  lar_dpath #(.COORD_W(COORD_W)) dpath_i (
    .clk     (clk),
    .rstN    (rstN),
    .myX     (myX),
    .myY     (myY),
    .inFlit  (inFlit),
    .strobe  (strobe),
    .outFlit (outFlit)
  );
endmodule

// File: rtl/lar_route_unit_chk.sv
module lar_route_unit_chk
  import lar_pkg::*;
#(
  parameter int COORD_W = 2
) (
  input logic               clk,
  input logic               rstN,
  input logic [COORD_W-1:0] myX,
  input logic [COORD_W-1:0] myY,
  input logic               inValid,
  input logic [FLIT_W-1:0]  inFlit,
  input logic               outValid,
  input logic [FLIT_W-1:0]  outFlit
);
  // output-side packet boundary tracker
  logic outIsHead;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         outIsHead <= 1'b1;
    else if (outValid) outIsHead <= outFlit[TAIL_B];
  end

  AST_RESET_QUIET: assert property (@(posedge clk) !rstN |=> !outValid); // R1
  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid); // R2
  AST_IDLE_FOLLOWS: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outValid); // R2
  AST_FIELDS_KEPT: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> (outFlit[PORT_LO-1:0] == $past(inFlit[PORT_LO-1:0]))
             && (outFlit[FLIT_W-1:XD_LO] == $past(inFlit[FLIT_W-1:XD_LO]))); // R4
  AST_BODY_PORT: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outIsHead) |-> outFlit[PORT_LO +: PORT_W] == $past(inFlit[PORT_LO +: PORT_W])); // R3
  AST_HEAD_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outIsHead) |-> $countones(outFlit[PORT_LO +: PORT_W]) == 1); // R10
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> $stable(outFlit)); // R11
endmodule

bind lar_route_unit lar_route_unit_chk #(.COORD_W(COORD_W)) chk_i (
  .clk(clk), .rstN(rstN), .myX(myX), .myY(myY), .inValid(inValid),
  .inFlit(inFlit), .outValid(outValid), .outFlit(outFlit)
);

// File: tb/lar_route_unit_tb_top.sv
module lar_route_unit_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int COORD_W = 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [COORD_W-1:0] myX = '0, myY = '0;
  logic inValid = 1'b0;
  logic [75:0] inFlit = '0;
  logic outValid;
  logic [75:0] outFlit;

  lar_route_unit #(.COORD_W(COORD_W)) dut_i (
    .clk(clk), .rstN(rstN), .myX(myX), .myY(myY), .inValid(inValid),
    .inFlit(inFlit), .outValid(outValid), .outFlit(outFlit)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  logic [75:0] expQ[$];
  string tagQ[$];
  logic [75:0] lastExp = '0;
  int nRun = 0, nFail = 0;
  bit done = 1'b0;

  localparam logic [4:0] N = 5'b00001, S = 5'b00010, E = 5'b00100, W = 5'b01000, L = 5'b10000;

  function automatic logic [4:0] modelPort(int cx, int cy, logic [4:0] p, int dx, int dy);
    int nx = cx;
    int ny = cy;
    if (p[0]) ny = cy + 1;
    else if (p[1]) ny = cy - 1;
    else if (p[2]) nx = cx + 1;
    else if (p[3]) nx = cx - 1;
    if (dx > nx) return E;
    if (dx < nx) return W;
    if (dy > ny) return N;
    if (dy < ny) return S;
    return L;
  endfunction

  task automatic check(input bit ok, input string tag, input logic [75:0] act, input logic [75:0] exp);
    nRun++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic sendFlit(input int cx, input int cy, input logic [63:0] data, input logic tail,
                          input logic [4:0] port, input int xd, input int yd, input bit head,
                          input string tag);
    logic [75:0] f;
    logic [75:0] e;
    @(negedge clk);
    f = {yd[2:0], xd[2:0], port, tail, data};
    e = f;
    if (head) e[69:65] = modelPort(cx, cy, port, xd, yd);
    myX = COORD_W'(cx);
    myY = COORD_W'(cy);
    inFlit = f;
    inValid = 1'b1;
    expQ.push_back(e);
    tagQ.push_back(tag);
    lastExp = e;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      inValid = 1'b0;
      inFlit = {76{1'b1}};
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rstN && !done && outValid) begin
      if (expQ.size() == 0) begin
        check(1'b0, "R2 unexpected output", outFlit, '0);
      end else begin
        logic [75:0] e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        check(outFlit === e, t, outFlit, e);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nFail++;
      $display("FAIL R2 watchdog actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

  initial begin
    // R1: valid input during reset is not passed on
    @(negedge clk);
    inValid = 1'b1;
    inFlit = {76{1'b1}};
    repeat (2) @(negedge clk);
    check(outValid === 1'b0, "R1 reset quiet", 76'(outValid), 76'(0));
    inValid = 1'b0;
    rstN = 1'b1;
    @(negedge clk);
    check(outValid === 1'b0, "R1 after release", 76'(outValid), 76'(0));
    idle(2);
    check(outValid === 1'b0, "R2 idle no output", 76'(outValid), 76'(0));

    // R9 first flit after reset is head; R6 east; R3 body/tail untouched
    sendFlit(1, 1, 64'h1111_2222_3333_4444, 1'b0, E, 3, 2, 1'b1, "R6 R9 head east");
    sendFlit(1, 1, 64'hAAAA_0000_BBBB_0001, 1'b0, 5'b01010, 3, 2, 1'b0, "R3 body unchanged");
    sendFlit(1, 1, 64'hAAAA_0000_BBBB_0002, 1'b1, 5'b00000, 3, 2, 1'b0, "R3 tail unchanged");
    // R7 vertical after x matches; R5 neighbour from north port
    sendFlit(1, 1, 64'h5, 1'b1, N, 1, 0, 1'b1, "R7 R5 south after north hop");
    sendFlit(1, 1, 64'h6, 1'b1, S, 1, 3, 1'b1, "R7 R5 north after south hop");
    // R6 x first even though y differs; R5 west hop
    sendFlit(2, 2, 64'h7, 1'b0, W, 0, 3, 1'b1, "R6 R5 west first");
    sendFlit(2, 2, 64'h8, 1'b1, E, 0, 0, 1'b0, "R3 tail keeps port");
    idle(3);
    check(outValid === 1'b0 && outFlit === lastExp, "R11 hold while idle", outFlit, lastExp);
    // R8 self when destination is the neighbour; R5 self port keeps own address
    sendFlit(2, 2, 64'h9, 1'b1, E, 3, 2, 1'b1, "R8 self at neighbour");
    sendFlit(0, 3, 64'hA, 1'b1, L, 0, 3, 1'b1, "R8 R5 self port own address");
    sendFlit(3, 0, 64'hB, 1'b1, 5'b00000, 1, 0, 1'b1, "R5 no port bit own address");
    // R5 priority: north bit wins over east bit
    sendFlit(1, 1, 64'hC, 1'b1, 5'b00101, 1, 1, 1'b1, "R5 priority north");
    // R9 R10 back-to-back single-flit packets, every destination
    for (int xd = 0; xd < 4; xd++)
      for (int yd = 0; yd < 4; yd++)
        sendFlit(1, 2, 64'(xd * 4 + yd), 1'b1, E, xd, yd, 1'b1, "R6 R7 R8 R9 R10 sweep");
    // R4 head keeps payload and destination with dense payload
    sendFlit(3, 3, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0, S, 3, 0, 1'b1, "R4 head fields kept");
    sendFlit(3, 3, 64'h0, 1'b1, 5'b11111, 3, 0, 1'b0, "R3 tail all ports set");
    idle(3);
    check(expQ.size() == 0, "R2 all flits delivered", 76'(expQ.size()), 76'(0));
    check(outValid === 1'b0 && outFlit === lastExp, "R11 final hold", outFlit, lastExp);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule